// File: doc/BRIEF.md
# Sector Erase Queue with Retriggerable Acceptance Window

This block collects sector-erase requests for a multi-sector flash model and then runs the embedded erase on every sector it collected. The first accepted request opens an acceptance window. Each later request that arrives while the window is open adds its sector to a one-bit-per-sector erase set and restarts the window. Requests may come in any order, and a sector may be named more than once.

When the window runs out with no new request, the block enters its erase phase. It visits the collected sectors from the lowest index to the highest. For each sector it drives three control phases of fixed length, in this order:

- program the sector to all zeros,
- verify that the sector reads as zeros,
- erase the sector to all ones.

Requests that arrive during the erase phase are dropped. When the last sector has been erased, the block pulses `done` once and becomes idle. Bus command decoding and real erase timing belong to the surrounding logic. `cmd_valid` stands for a fully decoded request: the final bus cycle of the six-cycle command sequence, which carries the sector address.

Top module: `sector_erase_queue`

## Requirements
- R1: After reset, `busy`, `done`, `erase_op` and `sect_sel` are all zero.
- R2: A request (`cmd_valid` high with `cmd_sector` below NUM_SECT) is accepted when the block is idle or collecting. `busy` is high from the cycle after the first accepted request until the erase phase ends.
- R3: The erase phase starts exactly WIN_CYC clock cycles after the most recent accepted request. A request sampled at the edge where the window would expire is still accepted, and it restarts the window.
- R4: Sectors may be queued in any order and in any number, from one up to all of them. Naming a sector that is already queued has no extra effect: the sector is erased once.
- R5: Queued sectors are processed in ascending index order.
- R6: For each sector, `erase_op` takes the values 01 (program to zeros), then 10 (verify zeros), then 11 (erase to ones). Each value lasts PHASE_CYC cycles, and the phases follow one another with no gap.
- R7: A request that arrives once the erase phase has begun is ignored. It does not add its sector to the current batch or to any later batch.
- R8: `done` is high for exactly one cycle, in the cycle right after the final erase phase. `busy` is already low in that cycle.
- R9: `sect_sel` is the one-hot mask of the sector being worked on whenever `erase_op` is non-zero, and it is all zeros when `erase_op` is 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Decoded sector-erase request strobe |
| cmd_sector | input | $clog2(NUM_SECT) | Target sector index of the request |
| busy | output | 1 | Collecting or erasing |
| erase_op | output | 2 | 00 none, 01 program zeros, 10 verify zeros, 11 erase to ones |
| sect_sel | output | NUM_SECT | One-hot select of the active sector |
| done | output | 1 | One-cycle pulse after the last sector is erased |

## Verification
A wrong erase-set bit shows up at the ports as a sector that is missing from, or added to, the `sect_sel` sequence. This becomes visible within three phase lengths of the moment the scan would reach that sector. A wrong window counter moves the first non-zero `erase_op` away from the cycle exactly WIN_CYC after the last accepted request, so it is caught in the first batch. A stuck phase counter or a stuck op state stretches or reorders the 01/10/11 runs, and `done` then arrives late or never, which the run-length log of every batch exposes.

// File: rtl/serq_pkg.sv
package serq_pkg;

    typedef enum logic [1:0] {
        OP_NONE   = 2'b00,
        OP_PROG0  = 2'b01,
        OP_VERIFY = 2'b10,
        OP_ERASE1 = 2'b11
    } erase_op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_COLLECT,
        ST_RUN
    } seq_state_e;

    // Index of the lowest set bit (0 when none). Supports up to 64 sectors.
    function automatic int unsigned lowest_set(input logic [63:0] v);
        int unsigned r;
        r = 0;
        for (int i = 63; i >= 0; i--) begin
            if (v[i]) r = i;
        end
        return r;
    endfunction

endpackage

// File: rtl/serq_window_timer.sv
module serq_window_timer #(
    parameter int WIN_CYC = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic run,
    output logic expire
);
    localparam int CW = (WIN_CYC > 1) ? $clog2(WIN_CYC) : 1;

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= CW'(WIN_CYC - 1);
        end else if (run && cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expire = run && !load && (cnt == '0);

    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(WIN_CYC - 1));

    p_reload_r3: assert property (@(posedge clk) disable iff (rst)
        load |=> (cnt == CW'(WIN_CYC - 1)));

endmodule

// File: rtl/serq_sector_set.sv
module serq_sector_set #(
    parameter int NUM_SECT = 8,
    localparam int SW = (NUM_SECT > 1) ? $clog2(NUM_SECT) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                set_en,
    input  logic [SW-1:0]       set_idx,
    input  logic                clr_en,
    input  logic [SW-1:0]       clr_idx,
    output logic [NUM_SECT-1:0] bits
);
    for (genvar g = 0; g < NUM_SECT; g++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                bits[g] <= 1'b0;
            end else if (set_en && set_idx == SW'(g)) begin
                bits[g] <= 1'b1;
            end else if (clr_en && clr_idx == SW'(g)) begin
                bits[g] <= 1'b0;
            end
        end
    end

    // Without a set request no new bit may appear.
    p_no_spurious_set_r7: assert property (@(posedge clk) disable iff (rst)
        !set_en |=> ((bits & ~$past(bits)) == '0));

    // A duplicate request leaves the set unchanged.
    p_dup_noeffect_r4: assert property (@(posedge clk) disable iff (rst)
        (set_en && !clr_en && bits[set_idx]) |=> (bits == $past(bits)));

endmodule

// File: rtl/serq_sequencer.sv
module serq_sequencer
    import serq_pkg::*;
#(
    parameter int NUM_SECT  = 8,
    parameter int PHASE_CYC = 4,
    localparam int SW = (NUM_SECT > 1) ? $clog2(NUM_SECT) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cmd_valid,
    input  logic [SW-1:0]       cmd_sector,
    input  logic [NUM_SECT-1:0] queued,
    input  logic                expire,
    output logic                accept,
    output logic                timer_run,
    output logic                clr_en,
    output logic [SW-1:0]       clr_idx,
    output logic [1:0]          op,
    output logic [NUM_SECT-1:0] sel,
    output logic                busy,
    output logic                done
);
    localparam int PCW = (PHASE_CYC > 1) ? $clog2(PHASE_CYC) : 1;
    localparam logic [SW:0] LIMIT = (SW+1)'(NUM_SECT);

    seq_state_e          state;
    erase_op_e           op_q;
    logic [SW-1:0]       cur;
    logic [PCW-1:0]      pcnt;
    logic                done_q;
    logic [NUM_SECT-1:0] cur_mask;
    logic [NUM_SECT-1:0] remaining;
    logic [SW-1:0]       first_idx;
    logic [SW-1:0]       next_idx;
    logic                phase_last;

    assign cur_mask   = NUM_SECT'(1) << cur;
    assign remaining  = queued & ~cur_mask;
    assign first_idx  = SW'(lowest_set(64'(queued)));
    assign next_idx   = SW'(lowest_set(64'(remaining)));
    assign phase_last = (pcnt == PCW'(PHASE_CYC - 1));

    assign accept    = cmd_valid && (state != ST_RUN) && ({1'b0, cmd_sector} < LIMIT);
    assign timer_run = (state == ST_COLLECT);
    assign clr_en    = (state == ST_RUN) && (op_q == OP_ERASE1) && phase_last;
    assign clr_idx   = cur;
    assign busy      = (state != ST_IDLE);
    assign done      = done_q;
    assign op        = op_q;
    assign sel       = (op_q != OP_NONE) ? cur_mask : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            op_q   <= OP_NONE;
            cur    <= '0;
            pcnt   <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (accept) state <= ST_COLLECT;
                end
                ST_COLLECT: begin
                    if (expire) begin
                        state <= ST_RUN;
                        cur   <= first_idx;
                        op_q  <= OP_PROG0;
                        pcnt  <= '0;
                    end
                end
                default: begin
                    if (!phase_last) begin
                        pcnt <= pcnt + 1'b1;
                    end else begin
                        pcnt <= '0;
                        case (op_q)
                            OP_PROG0:  op_q <= OP_VERIFY;
                            OP_VERIFY: op_q <= OP_ERASE1;
                            default: begin
                                if (remaining != '0) begin
                                    cur  <= next_idx;
                                    op_q <= OP_PROG0;
                                end else begin
                                    state  <= ST_IDLE;
                                    op_q   <= OP_NONE;
                                    done_q <= 1'b1;
                                end
                            end
                        endcase
                    end
                end
            endcase
        end
    end

    p_sel_onehot_r9: assert property (@(posedge clk) disable iff (rst)
        (op_q != OP_NONE) |-> ($countones(sel) == 1));

    p_sel_idle_r9: assert property (@(posedge clk) disable iff (rst)
        (op_q == OP_NONE) |-> (sel == '0));

    p_verify_after_prog_r6: assert property (@(posedge clk) disable iff (rst)
        (op_q == OP_VERIFY && $past(op_q) != OP_VERIFY) |-> ($past(op_q) == OP_PROG0));

    p_erase_after_verify_r6: assert property (@(posedge clk) disable iff (rst)
        (op_q == OP_ERASE1 && $past(op_q) != OP_ERASE1) |-> ($past(op_q) == OP_VERIFY));

    p_ascending_r5: assert property (@(posedge clk) disable iff (rst)
        (op_q == OP_PROG0 && $past(op_q) == OP_ERASE1) |-> (cur > $past(cur)));

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_done_idle_r8: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

endmodule

// File: rtl/sector_erase_queue.sv
module sector_erase_queue #(
    parameter int NUM_SECT  = 8,
    parameter int WIN_CYC   = 16,
    parameter int PHASE_CYC = 4,
    localparam int SW = (NUM_SECT > 1) ? $clog2(NUM_SECT) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cmd_valid,
    input  logic [SW-1:0]       cmd_sector,
    output logic                busy,
    output logic [1:0]          erase_op,
    output logic [NUM_SECT-1:0] sect_sel,
    output logic                done
);
    logic                accept;
    logic                timer_run;
    logic                expire;
    logic                clr_en;
    logic [SW-1:0]       clr_idx;
    logic [NUM_SECT-1:0] queued;

    serq_window_timer #(.WIN_CYC(WIN_CYC)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .load   (accept),
        .run    (timer_run),
        .expire (expire)
    );

    serq_sector_set #(.NUM_SECT(NUM_SECT)) u_set (
        .clk     (clk),
        .rst     (rst),
        .set_en  (accept),
        .set_idx (cmd_sector),
        .clr_en  (clr_en),
        .clr_idx (clr_idx),
        .bits    (queued)
    );

    serq_sequencer #(.NUM_SECT(NUM_SECT), .PHASE_CYC(PHASE_CYC)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .cmd_valid  (cmd_valid),
        .cmd_sector (cmd_sector),
        .queued     (queued),
        .expire     (expire),
        .accept     (accept),
        .timer_run  (timer_run),
        .clr_en     (clr_en),
        .clr_idx    (clr_idx),
        .op         (erase_op),
        .sel        (sect_sel),
        .busy       (busy),
        .done       (done)
    );

    p_done_empty_r8: assert property (@(posedge clk) disable iff (rst)
        done |-> (queued == '0));

    p_ops_busy_r2: assert property (@(posedge clk) disable iff (rst)
        (erase_op != 2'b00) |-> busy);

endmodule

// File: tb/sim_sector_erase_queue.sv
module sim_sector_erase_queue;
    localparam int NS = 8;
    localparam int W  = 16;
    localparam int PH = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         cmd_valid = 1'b0;
    logic [2:0]   cmd_sector = '0;
    logic         busy;
    logic [1:0]   erase_op;
    logic [NS-1:0] sect_sel;
    logic         done;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;

    int seg_op [0:63];
    int seg_sec[0:63];
    int seg_len[0:63];
    int seg_n = 0;
    bit prev_act = 0;

    always #2.5 clk = ~clk;

    sector_erase_queue #(.NUM_SECT(NS), .WIN_CYC(W), .PHASE_CYC(PH)) u0 (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_sector(cmd_sector),
        .busy(busy), .erase_op(erase_op), .sect_sel(sect_sel), .done(done)
    );

    // Run-length log of (sector, op) seen at the ports.
    always @(negedge clk) begin
        cyc++;
        if (erase_op != 2'b00) begin
            int sec;
            sec = -1;
            if ($countones(sect_sel) == 1)
                for (int i = 0; i < NS; i++) if (sect_sel[i]) sec = i;
            if (prev_act && seg_n > 0 && seg_op[seg_n-1] == int'(erase_op) && seg_sec[seg_n-1] == sec)
                seg_len[seg_n-1]++;
            else if (seg_n < 64) begin
                seg_op[seg_n] = int'(erase_op);
                seg_sec[seg_n] = sec;
                seg_len[seg_n] = 1;
                seg_n++;
            end
            prev_act = 1;
        end else prev_act = 0;
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic send(input int s);
        cmd_valid = 1'b1;
        cmd_sector = 3'(s);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Called right after the last send: counts collect cycles until first op.
    task automatic measure_window();
        int n;
        n = 1;
        while (erase_op == 2'b00 && n < 200) begin
            @(negedge clk);
            n++;
        end
        chk(n - 1 == W, "R3", "window cycles", n - 1, W);
    endtask

    task automatic wait_done();
        int n;
        n = 0;
        while (!done && n < 3000) begin
            @(negedge clk);
            n++;
        end
        chk(done == 1'b1, "R8", "done seen", int'(done), 1);
        chk(busy == 1'b0, "R8", "busy low with done", int'(busy), 0);
        @(negedge clk);
        chk(done == 1'b0, "R8", "done one cycle", int'(done), 0);
    endtask

    // Expected: each sector in list gives three runs 1,2,3 of PH cycles.
    task automatic check_segs(input int exp_sec[], input string req);
        chk(seg_n == 3 * exp_sec.size(), req, "segment count", seg_n, 3 * exp_sec.size());
        for (int i = 0; i < exp_sec.size() && 3*i+2 < seg_n; i++) begin
            for (int p = 0; p < 3; p++) begin
                chk(seg_sec[3*i+p] == exp_sec[i], req, "sector order (R5)", seg_sec[3*i+p], exp_sec[i]);
                chk(seg_op[3*i+p] == p + 1, "R6", "op sequence", seg_op[3*i+p], p + 1);
                chk(seg_len[3*i+p] == PH, "R6", "phase length", seg_len[3*i+p], PH);
            end
        end
    endtask

    task automatic t_reset();
        chk(busy == 0, "R1", "busy", int'(busy), 0);
        chk(done == 0, "R1", "done", int'(done), 0);
        chk(erase_op == 0, "R1", "erase_op", int'(erase_op), 0);
        chk(sect_sel == 0, "R9", "sect_sel at reset (R1)", int'(sect_sel), 0);
    endtask

    task automatic t_single();
        seg_n = 0;
        send(5);
        chk(busy == 1, "R2", "busy after accept", int'(busy), 1);
        chk(erase_op == 0, "R9", "no op while collecting", int'(erase_op), 0);
        measure_window();
        chk(sect_sel == 8'h20, "R9", "sel one-hot", int'(sect_sel), 32);
        wait_done();
        check_segs('{5}, "R5");
    endtask

    task automatic t_multi();
        seg_n = 0;
        send(6); idle(W - 1);
        send(2); idle(W - 1);
        send(2); idle(W - 1);
        send(0);
        measure_window();
        wait_done();
        check_segs('{0, 2, 6}, "R4");
    endtask

    task automatic t_ignore();
        seg_n = 0;
        send(3);
        measure_window();
        send(1);
        wait_done();
        check_segs('{3}, "R7");
        idle(2);
        chk(busy == 0, "R7", "stays idle after done", int'(busy), 0);
        seg_n = 0;
        send(5);
        measure_window();
        wait_done();
        check_segs('{5}, "R7");
    endtask

    task automatic t_late();
        seg_n = 0;
        send(4); idle(W);
        send(1);
        wait_done();
        check_segs('{4}, "R3");
    endtask

    task automatic t_all();
        seg_n = 0;
        for (int s = NS - 1; s >= 0; s--) send(s);
        measure_window();
        wait_done();
        check_segs('{0, 1, 2, 3, 4, 5, 6, 7}, "R4");
    endtask

    initial begin
        idle(3);
        t_reset();
        rst = 1'b0;
        idle(2);
        t_reset();
        t_single();
        t_multi();
        t_ignore();
        t_late();
        t_all();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(5.0 * 100000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule